// File: doc/BRIEF.md
# Keyed Diagnostic Reset Unlock

This register block protects a storage controller's adapter soft reset from being fired by accident. Software first writes a fixed six-word key to a sequence register, one word per write and in the right order. Once every word has matched, a write-enable flag appears in bit 7 of a diagnostic register. A write to the diagnostic register that has bit 2 set is then accepted. It produces a one-clock reset request pulse and returns the unlock logic to its locked idle state.

Any word that does not match the expected key entry discards all progress and clears the diagnostic register. A wrong word is never treated as the start of a new attempt, even when it equals the first key word. After the key is complete, one more write to the sequence register locks the block again. Access is through a simple register bus. Reads are registered and return with a valid flag. Offsets that are not mapped ignore writes and read as zero.

Top module: `diag_unlock`

## Requirements
- R1: After the synchronous active-high reset, the diagnostic register reads 0, and both the read-valid flag and the reset request are low.
- R2: The key is 0x00, 0x04, 0x0B, 0x02, 0x07, 0x0D, written to the sequence register at offset 0xFC. Once all six words have matched in order, the diagnostic register at offset 0xF8 reads 0x00000080 (bit 7 = write-enable). Before the sixth word it reads 0.
- R3: A sequence-register write that does not match the expected key word sets progress and the diagnostic register to 0. The mismatching word does not count as the first key word, so a wrong 0x00 followed by the remaining five words does not unlock.
- R4: While unlocked, any further write to the sequence register clears the diagnostic register to 0 and restarts progress from the first key word.
- R5: A write to offset 0xF8 is accepted when write-enable is set and bit 2 of the data is 1. The reset request is then high for exactly the one cycle after the write edge. Afterwards the diagnostic register reads 0 and the key must be entered again from its first word.
- R6: A diagnostic-register write while locked, or with bit 2 of the data clear, raises no reset request and leaves the diagnostic register unchanged.
- R7: A read strobe produces read-valid for exactly the following cycle. The read data is then the diagnostic register for offset 0xF8, zero for offset 0xFC, and zero for any other offset.
- R8: Writes to unmapped offsets change neither the key progress nor the diagnostic register, and raise no reset request.
- R9: The synchronous reset discards partial key progress and clears an unlocked diagnostic register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | High the cycle after a read strobe |
| adpResetReq | output | 1 | One-cycle adapter reset request |

## Verification
Every result is due one clock edge after the stimulus that causes it. A sequence or diagnostic write updates the diagnostic register at its own edge. An accepted diagnostic write raises the reset request for the single cycle after that edge. A read strobe returns its data and read-valid in the cycle after its edge. The bench drives each access on a falling edge and holds it across one rising edge. It samples the reset request at the next falling edge, and checks one cycle later that the pulse has dropped. Register contents are always observed with a separate read, so the value being checked is the one left after the previous write has settled.

// File: rtl/diag_unlock_pkg.sv
package diag_unlock_pkg;

  localparam int KEY_LEN = 6;
  localparam int WE_BIT  = 7;
  localparam int RST_BIT = 2;

  typedef struct packed {
    logic advance;  // sequence word matched the expected key entry
    logic relock;   // sequence word rejected: drop progress and diag
    logic unlock;   // final key word matched: raise write-enable
    logic fire;     // accepted diag write: pulse reset, clear state
  } ctrlStrobes_t;

  function automatic logic [7:0] keyWord(input int unsigned idx);
    case (idx)
      0:       keyWord = 8'h00;
      1:       keyWord = 8'h04;
      2:       keyWord = 8'h0B;
      3:       keyWord = 8'h02;
      4:       keyWord = 8'h07;
      5:       keyWord = 8'h0D;
      default: keyWord = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/diag_unlock_ctrl.sv
module diag_unlock_ctrl
  import diag_unlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIAG_OFS = 'hF8,
  parameter int SEQ_OFS  = 'hFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              diagWe,
  output ctrlStrobes_t      strobes
);

  localparam int IDX_W = $clog2(KEY_LEN + 1);
  localparam int SLOTS = 2 ** IDX_W;

  logic [IDX_W-1:0] progress;
  logic [SLOTS-1:0] entryMatch;
  logic             seqHit;
  logic             diagHit;
  logic             keyMatch;

  assign seqHit  = wrEn && (addr == ADDR_W'(SEQ_OFS));
  assign diagHit = wrEn && (addr == ADDR_W'(DIAG_OFS));

  // One comparator per key entry; slots past the key never match,
  // which makes a saturated index treat every word as a mismatch.
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (g < KEY_LEN) begin : gKey
      assign entryMatch[g] = (wrData == {{(DATA_W-8){1'b0}}, keyWord(g)});
    end else begin : gPad
      assign entryMatch[g] = 1'b0;
    end
  end

  assign keyMatch = entryMatch[progress];

  always_comb begin
    strobes         = '0;
    strobes.advance = seqHit && keyMatch;
    strobes.relock  = seqHit && !keyMatch;
    strobes.unlock  = seqHit && keyMatch && (progress == IDX_W'(KEY_LEN - 1));
    strobes.fire    = diagHit && diagWe && wrData[RST_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.fire || strobes.relock) begin
      progress <= '0;
    end else if (strobes.advance) begin
      progress <= progress + IDX_W'(1);
    end
  end

  // R2: progress never passes the key length
  assert_progress_bound_R2: assert property (@(posedge clk) disable iff (rst)
    progress <= IDX_W'(KEY_LEN));

  // R3: progress moves only by one step forward or back to zero
  assert_progress_step_R3: assert property (@(posedge clk) disable iff (rst)
    (progress != $past(progress)) |-> (progress == '0 || progress == $past(progress) + IDX_W'(1)));

  // R8: a write to any other offset leaves progress alone
  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !seqHit && !diagHit) |=> $stable(progress));

endmodule

// File: rtl/diag_unlock_dp.sv
module diag_unlock_dp
  import diag_unlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIAG_OFS = 'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic              diagWe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              adpResetReq
);

  localparam logic [DATA_W-1:0] WE_VALUE = DATA_W'(1) << WE_BIT;

  logic [DATA_W-1:0] diagReg;

  always_ff @(posedge clk) begin
    if (rst || strobes.fire || strobes.relock) begin
      diagReg <= '0;
    end else if (strobes.unlock) begin
      diagReg <= WE_VALUE;
    end
  end

  assign diagWe = diagReg[WE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      adpResetReq <= 1'b0;
    end else begin
      adpResetReq <= strobes.fire;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        rdData <= (addr == ADDR_W'(DIAG_OFS)) ? diagReg : '0;
      end
    end
  end

  // R2: the diag register only holds zero or the write-enable value
  assert_diag_values_R2: assert property (@(posedge clk) disable iff (rst)
    (diagReg == '0) || (diagReg == WE_VALUE));

  // R2: the last key word leaves write-enable set
  assert_unlock_sets_we_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.unlock |=> diagWe);

  // R5: the reset request lasts one cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    adpResetReq |=> !adpResetReq);

  // R5: while the request is high the unlock state is already gone
  assert_pulse_clears_R5: assert property (@(posedge clk) disable iff (rst)
    adpResetReq |-> (diagReg == '0));

  // R6: a key step and an accepted diag write never coincide
  assert_strobes_disjoint_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |-> !strobes.fire);

  // R7: reads of any offset other than diag return zero
  assert_rd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr != ADDR_W'(DIAG_OFS)) |=> (rdValid && rdData == '0));

endmodule

// File: rtl/diag_unlock.sv
module diag_unlock
  import diag_unlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIAG_OFS = 'hF8,
  parameter int SEQ_OFS  = 'hFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              adpResetReq
);

  ctrlStrobes_t strobes;
  logic         diagWe;

  diag_unlock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIAG_OFS(DIAG_OFS), .SEQ_OFS(SEQ_OFS)
  ) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .diagWe(diagWe), .strobes(strobes)
  );

  diag_unlock_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIAG_OFS(DIAG_OFS)
  ) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .rdEn(rdEn), .addr(addr),
    .diagWe(diagWe), .rdData(rdData), .rdValid(rdValid),
    .adpResetReq(adpResetReq)
  );

endmodule

// File: tb/test_diag_unlock.sv
module test_diag_unlock;

  localparam logic [7:0] DIAG = 8'hF8;
  localparam logic [7:0] SEQ  = 8'hFC;
  localparam logic [7:0] HOLE = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        adpResetReq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  diag_unlock i_diag_unlock (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .adpResetReq(adpResetReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output bit pulse);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    pulse = adpResetReq;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check("R7 rdValid after strobe", {31'b0, rdValid}, 32'd1);
    d = rdData;
  endtask

  task automatic seqWords(input logic [7:0] w0, input int n);
    bit p;
    logic [7:0] k [6] = '{8'h00, 8'h04, 8'h0B, 8'h02, 8'h07, 8'h0D};
    for (int i = w0; i < w0 + n; i++) busWrite(SEQ, {24'b0, k[i]}, p);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    check("R1 rdValid idle", {31'b0, rdValid}, 32'd0);
    check("R1 reset request idle", {31'b0, adpResetReq}, 32'd0);
    busRead(DIAG, d);
    check("R1 diag after reset", d, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    doReset();
    seqWords(0, 5);
    busRead(DIAG, d);
    check("R2 diag after five words", d, 32'h0);
    seqWords(5, 1);
    busRead(DIAG, d);
    check("R2 diag unlocked", d, 32'h80);
  endtask

  task automatic t_mismatch();
    logic [31:0] d;
    bit p;
    doReset();
    seqWords(0, 3);
    busWrite(SEQ, 32'h05, p);
    seqWords(3, 3);
    busRead(DIAG, d);
    check("R3 wrong word drops progress", d, 32'h0);
    seqWords(0, 2);
    busWrite(SEQ, 32'h00, p);
    seqWords(1, 5);
    busRead(DIAG, d);
    check("R3 wrong 0x00 is no restart", d, 32'h0);
    seqWords(0, 6);
    busRead(DIAG, d);
    check("R3 clean key still unlocks", d, 32'h80);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    bit p;
    doReset();
    seqWords(0, 6);
    busWrite(SEQ, 32'h00, p);
    busRead(DIAG, d);
    check("R4 extra word relocks", d, 32'h0);
    seqWords(1, 5);
    busRead(DIAG, d);
    check("R4 progress restarted", d, 32'h0);
  endtask

  task automatic t_fire();
    logic [31:0] d;
    bit p;
    doReset();
    seqWords(0, 6);
    busWrite(DIAG, 32'h84, p);
    check("R5 pulse after accepted write", {31'b0, p}, 32'd1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, adpResetReq}, 32'd0);
    busRead(DIAG, d);
    check("R5 diag cleared", d, 32'h0);
    seqWords(1, 5);
    busRead(DIAG, d);
    check("R5 progress cleared", d, 32'h0);
    seqWords(0, 6);
    busRead(DIAG, d);
    check("R5 unlock again", d, 32'h80);
  endtask

  task automatic t_noeffect();
    logic [31:0] d;
    bit p;
    doReset();
    busWrite(DIAG, 32'h04, p);
    check("R6 locked write no pulse", {31'b0, p}, 32'd0);
    busRead(DIAG, d);
    check("R6 locked write diag", d, 32'h0);
    seqWords(0, 6);
    busWrite(DIAG, 32'hFFFF_FFFB, p);
    check("R6 bit2 clear no pulse", {31'b0, p}, 32'd0);
    busRead(DIAG, d);
    check("R6 bit2 clear diag kept", d, 32'h80);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    doReset();
    seqWords(0, 6);
    busRead(SEQ, d);
    check("R7 sequence reg reads zero", d, 32'h0);
    busRead(HOLE, d);
    check("R7 unmapped reads zero", d, 32'h0);
    busRead(DIAG, d);
    check("R7 diag readback", d, 32'h80);
    @(negedge clk);
    check("R7 rdValid single cycle", {31'b0, rdValid}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bit p;
    doReset();
    seqWords(0, 2);
    busWrite(HOLE, 32'h0B, p);
    busWrite(HOLE, 32'hFF, p);
    seqWords(2, 4);
    busRead(DIAG, d);
    check("R8 unmapped writes ignored by key", d, 32'h80);
    busWrite(HOLE, 32'h84, p);
    check("R8 unmapped write no pulse", {31'b0, p}, 32'd0);
    busRead(DIAG, d);
    check("R8 diag kept", d, 32'h80);
  endtask

  task automatic t_syncrst();
    logic [31:0] d;
    doReset();
    seqWords(0, 3);
    doReset();
    seqWords(3, 3);
    busRead(DIAG, d);
    check("R9 reset drops progress", d, 32'h0);
    seqWords(0, 6);
    doReset();
    busRead(DIAG, d);
    check("R9 reset clears unlock", d, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unlock();
    t_mismatch();
    t_relock();
    t_fire();
    t_noeffect();
    t_reads();
    t_unmapped();
    t_syncrst();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule